// File: doc/BRIEF.md
# Vectored Interrupt Acknowledge Controller

This block sits between one interrupting peripheral and a processor core. The peripheral requests service by pulling an active-low line. The controller waits until the core says it can take an interrupt, then acknowledges the peripheral. The peripheral answers with a vector number on a small bus, marked by a one-cycle valid strobe. The controller latches that number and uses it to index a software-written table of handler start addresses. The selected address goes to the core as a redirect target, with a one-cycle valid pulse.

The table is written through its own synchronous port, so each session can load its own set of handlers. A peripheral that never returns a vector is dropped after a fixed acknowledge window, and a one-cycle error pulse is raised. After a request has been served or dropped, the line must go high again before another request is taken. This stops a level held low from being serviced twice.

Top module: `vec_irq_ctrl`

## Requirements
- R1: In reset and on the first cycle after it, `ack`, `handler_valid` and `spurious_err` are low.
- R2: `irq_n` is active-low and passes through a two-flop synchroniser. `ack` stays low while `core_ready` is low. Once the controller is waiting for the core, `ack` goes high in the cycle after `core_ready` is sampled high.
- R3: `ack` stays high until `vec_valid` is sampled high. It goes low in the cycle after that strobe.
- R4: Two cycles after the `vec_valid` strobe, `handler_valid` is high for exactly one cycle. In that cycle `handler_addr` holds the table entry indexed by the captured `vec_in` value.
- R5: A table write with `tbl_we` high stores `tbl_wdata` at `tbl_addr` on the clock edge. Every one of the 2^VEC_W entries, including 0 and the highest index, can be written and then read back through a service.
- R6: A write to the entry being looked up, in the cycle right after the strobe, does not change the address being issued: the old value is issued. The new value is used from the next service on.
- R7: If `vec_valid` does not arrive, `ack` stays high for exactly TMO_CYC (16) cycles and then drops. In the cycle `ack` drops, `spurious_err` is high for one cycle and no handler is issued.
- R8: A `vec_valid` strobe that arrives in the last (16th) cycle of `ack` is accepted as a normal vector.
- R9: After a service or a timeout, a line still held low is ignored: `ack` does not rise again until `irq_n` has been seen high and then low again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_n | input | 1 | Peripheral request, active-low, asynchronous |
| core_ready | input | 1 | Core can accept an interrupt |
| ack | output | 1 | Acknowledge to the peripheral |
| vec_in | input | VEC_W (8) | Vector number returned by the peripheral |
| vec_valid | input | 1 | One-cycle strobe marking `vec_in` valid |
| tbl_we | input | 1 | Table write enable |
| tbl_addr | input | VEC_W (8) | Table write index |
| tbl_wdata | input | ADDR_W (32) | Handler address to store |
| handler_addr | output | ADDR_W (32) | Handler start address for the core |
| handler_valid | output | 1 | One-cycle pulse, `handler_addr` is valid |
| spurious_err | output | 1 | One-cycle pulse, acknowledge window expired |

## Verification
Two events can land on the same clock edge: a table write, and the table read that the lookup stage makes for the captured vector. The bench forces this by driving a write to the entry being looked up in the cycle right after the strobe. It then expects the old address on the issue pulse and the new address on the next service of that vector. A second overlap is the timeout and the strobe: the bench drives `vec_valid` in the final cycle of the window and expects a normal issue with no error pulse.

// File: rtl/vic_pkg.sv
package vic_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_WAIT_RDY,
    S_ACK,
    S_WAIT_VEC,
    S_LOOKUP,
    S_ISSUE
  } vic_state_t;
endpackage

// File: rtl/vic_sync.sv
module vic_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din_n,
  output logic dout_n
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[i] <= 1'b1;
          else     chain[i] <= din_n;
        end
      end else begin : g_rest
        always_ff @(posedge clk) begin
          if (rst) chain[i] <= 1'b1;
          else     chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign dout_n = chain[STAGES-1];
endmodule

// File: rtl/vic_table.sv
module vic_table #(
  parameter int IDX_W  = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // read from a registered index; old data on a same-cycle write
  assign rdata = mem[raddr];
endmodule

// File: rtl/vic_fsm.sv
module vic_fsm
  import vic_pkg::*;
#(
  parameter int VEC_W   = 8,
  parameter int TMO_CYC = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             line_n,
  input  logic             core_ready,
  input  logic [VEC_W-1:0] vec_in,
  input  logic             vec_valid,
  output logic             ack,
  output logic [VEC_W-1:0] vec_q,
  output logic             lookup,
  output logic             handler_valid,
  output logic             spurious_err
);
  localparam int TMR_W = $clog2(TMO_CYC + 1);
  localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(TMO_CYC - 1);

  vic_state_t state, nxt;
  logic [TMR_W-1:0] timer;
  logic armed;
  logic in_ack, tmo_hit;

  assign in_ack  = (state == S_ACK) || (state == S_WAIT_VEC);
  assign tmo_hit = in_ack && !vec_valid && (timer == TMR_LAST);
  assign lookup  = (state == S_LOOKUP);

  always_comb begin
    nxt = state;
    unique case (state)
      S_IDLE:     if (armed && !line_n) nxt = S_WAIT_RDY;
      S_WAIT_RDY: if (core_ready) nxt = S_ACK;
      S_ACK, S_WAIT_VEC: begin
        if (vec_valid)    nxt = S_LOOKUP;
        else if (tmo_hit) nxt = S_IDLE;
        else              nxt = S_WAIT_VEC;
      end
      S_LOOKUP:   nxt = S_ISSUE;
      S_ISSUE:    nxt = S_IDLE;
      default:    nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= S_IDLE;
      timer         <= '0;
      armed         <= 1'b0;
      ack           <= 1'b0;
      handler_valid <= 1'b0;
      spurious_err  <= 1'b0;
      vec_q         <= '0;
    end else begin
      state         <= nxt;
      ack           <= (nxt == S_ACK) || (nxt == S_WAIT_VEC);
      handler_valid <= (nxt == S_ISSUE);
      spurious_err  <= tmo_hit;
      if (in_ack) timer <= timer + 1'b1;
      else        timer <= '0;
      if (state == S_IDLE) begin
        if (line_n)     armed <= 1'b1;
        else if (armed) armed <= 1'b0;
      end
      if (in_ack && vec_valid) vec_q <= vec_in;
    end
  end

  // checker state: length of the current acknowledge run
  logic [TMR_W:0] ack_run;
  always_ff @(posedge clk) begin
    if (rst)      ack_run <= '0;
    else if (ack) ack_run <= ack_run + 1'b1;
    else          ack_run <= '0;
  end

  // R2
  ack_ready_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ack) |-> $past(core_ready));

  // R3
  ack_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (ack && !vec_valid) |=> (ack || spurious_err));

  // R4
  hv_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    handler_valid |=> !handler_valid);

  // R7
  err_excl_chk: assert property (@(posedge clk) disable iff (rst)
    spurious_err |-> (!ack && !handler_valid));

  // R7
  ack_window_chk: assert property (@(posedge clk) disable iff (rst)
    ack_run <= (TMR_W+1)'(TMO_CYC));

  // R9
  no_rerequest_chk: assert property (@(posedge clk) disable iff (rst)
    handler_valid |=> !ack);
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl #(
  parameter int VEC_W       = 8,
  parameter int ADDR_W      = 32,
  parameter int TMO_CYC     = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              irq_n,
  input  logic              core_ready,
  output logic              ack,
  input  logic [VEC_W-1:0]  vec_in,
  input  logic              vec_valid,
  input  logic              tbl_we,
  input  logic [VEC_W-1:0]  tbl_addr,
  input  logic [ADDR_W-1:0] tbl_wdata,
  output logic [ADDR_W-1:0] handler_addr,
  output logic              handler_valid,
  output logic              spurious_err
);
  logic              line_n;
  logic [VEC_W-1:0]  vec_q;
  logic              lookup;
  logic [ADDR_W-1:0] rd_data;

  vic_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .din_n  (irq_n),
    .dout_n (line_n)
  );

  vic_fsm #(.VEC_W(VEC_W), .TMO_CYC(TMO_CYC)) u_fsm (
    .clk           (clk),
    .rst           (rst),
    .line_n        (line_n),
    .core_ready    (core_ready),
    .vec_in        (vec_in),
    .vec_valid     (vec_valid),
    .ack           (ack),
    .vec_q         (vec_q),
    .lookup        (lookup),
    .handler_valid (handler_valid),
    .spurious_err  (spurious_err)
  );

  vic_table #(.IDX_W(VEC_W), .DATA_W(ADDR_W)) u_table (
    .clk   (clk),
    .we    (tbl_we),
    .waddr (tbl_addr),
    .wdata (tbl_wdata),
    .raddr (vec_q),
    .rdata (rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst)         handler_addr <= '0;
    else if (lookup) handler_addr <= rd_data;
  end

  // R4
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(handler_valid) |-> $stable(handler_addr));
endmodule

// File: tb/sim_vec_irq_ctrl.sv
module sim_vec_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        irq_n = 1'b1;
  logic        core_ready = 1'b0;
  logic        ack;
  logic [7:0]  vec_in = '0;
  logic        vec_valid = 1'b0;
  logic        tbl_we = 1'b0;
  logic [7:0]  tbl_addr = '0;
  logic [31:0] tbl_wdata = '0;
  logic [31:0] handler_addr;
  logic        handler_valid;
  logic        spurious_err;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  vec_irq_ctrl u0 (
    .clk(clk), .rst(rst), .irq_n(irq_n), .core_ready(core_ready), .ack(ack),
    .vec_in(vec_in), .vec_valid(vec_valid), .tbl_we(tbl_we), .tbl_addr(tbl_addr),
    .tbl_wdata(tbl_wdata), .handler_addr(handler_addr),
    .handler_valid(handler_valid), .spurious_err(spurious_err)
  );

  // {vector, handler address}
  localparam logic [39:0] CASES [8] = '{
    {8'h00, 32'h0000_1000}, {8'hFF, 32'hFFFF_FFFC},
    {8'h21, 32'h0040_2100}, {8'h08, 32'h0000_0800},
    {8'h80, 32'h8000_0000}, {8'h7F, 32'h1234_5678},
    {8'h01, 32'hDEAD_BEE0}, {8'hA5, 32'h0A5A_5A50}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    tbl_we = 1'b1; tbl_addr = a; tbl_wdata = d;
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  // raise the request and wait for ack; returns at the negedge of first ack sample
  task automatic request(output bit seen);
    seen = 0;
    @(negedge clk);
    irq_n = 1'b0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (ack) begin seen = 1; break; end
    end
  endtask

  task automatic release_line();
    irq_n = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  // full service; optional same-cycle write during lookup
  task automatic serve(input logic [7:0] v, input logic [31:0] exp,
                       input bit clash, input logic [31:0] clash_data);
    bit seen;
    request(seen);
    chk(seen, "R2 ack seen", 32'(ack), 32'd1);
    vec_in = v; vec_valid = 1'b1;
    @(negedge clk);
    vec_valid = 1'b0;
    chk(ack == 1'b0, "R3 ack drops after strobe", 32'(ack), 32'd0);
    if (clash) begin tbl_we = 1'b1; tbl_addr = v; tbl_wdata = clash_data; end
    @(negedge clk);
    tbl_we = 1'b0;
    chk(handler_valid == 1'b1, "R4 handler_valid", 32'(handler_valid), 32'd1);
    chk(handler_addr == exp, clash ? "R6 old value issued" : "R4 R5 handler_addr",
        handler_addr, exp);
    @(negedge clk);
    chk(handler_valid == 1'b0, "R4 pulse one cycle", 32'(handler_valid), 32'd0);
    release_line();
  endtask

  initial begin
    bit seen;
    int highs;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!ack && !handler_valid && !spurious_err, "R1 outputs in reset",
        {29'd0, ack, handler_valid, spurious_err}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk(!ack && !handler_valid && !spurious_err, "R1 outputs after reset",
        {29'd0, ack, handler_valid, spurious_err}, 32'd0);

    // R5 load table
    foreach (CASES[i]) wr(CASES[i][39:32], CASES[i][31:0]);

    // R2 ack held back while core not ready
    irq_n = 1'b0;
    highs = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (ack) highs++;
    end
    chk(highs == 0, "R2 no ack without core_ready", 32'(highs), 32'd0);
    core_ready = 1'b1;
    @(negedge clk);
    chk(ack == 1'b1, "R2 ack one cycle after core_ready", 32'(ack), 32'd1);
    vec_in = 8'h21; vec_valid = 1'b1;
    @(negedge clk);
    vec_valid = 1'b0;
    chk(ack == 1'b0, "R3 ack drop", 32'(ack), 32'd0);
    @(negedge clk);
    chk(handler_valid && handler_addr == 32'h0040_2100, "R4 first issue",
        handler_addr, 32'h0040_2100);
    release_line();

    // table walk (R4 R5)
    foreach (CASES[i]) serve(CASES[i][39:32], CASES[i][31:0], 1'b0, 32'd0);

    // R6 same-cycle write to looked-up entry
    serve(8'h21, 32'h0040_2100, 1'b1, 32'h0BAD_F00D);
    serve(8'h21, 32'h0BAD_F00D, 1'b0, 32'd0);

    // R7 timeout
    request(seen);
    highs = seen ? 1 : 0;
    for (int i = 0; i < 30 && ack; i++) begin
      @(negedge clk);
      if (ack) highs++;
      else break;
    end
    chk(highs == 16, "R7 ack window length", 32'(highs), 32'd16);
    chk(spurious_err == 1'b1, "R7 error pulse", 32'(spurious_err), 32'd1);
    chk(handler_valid == 1'b0, "R7 no issue", 32'(handler_valid), 32'd0);
    @(negedge clk);
    chk(spurious_err == 1'b0, "R7 error one cycle", 32'(spurious_err), 32'd0);
    // R9 line still low after timeout: ignored
    highs = 0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (ack) highs++;
    end
    chk(highs == 0, "R9 held line ignored after timeout", 32'(highs), 32'd0);
    release_line();

    // R8 strobe in final ack cycle
    request(seen);
    highs = 1;
    while (highs < 16) begin
      @(negedge clk);
      highs++;
    end
    chk(ack == 1'b1, "R8 ack in 16th cycle", 32'(ack), 32'd1);
    vec_in = 8'hFF; vec_valid = 1'b1;
    @(negedge clk);
    vec_valid = 1'b0;
    chk(spurious_err == 1'b0, "R8 no error", 32'(spurious_err), 32'd0);
    @(negedge clk);
    chk(handler_valid && handler_addr == 32'hFFFF_FFFC, "R8 late strobe issued",
        handler_addr, 32'hFFFF_FFFC);

    // R9 line held low after service
    highs = 0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (ack) highs++;
    end
    chk(highs == 0, "R9 held line ignored after service", 32'(highs), 32'd0);
    release_line();
    serve(8'h08, 32'h0000_0800, 1'b0, 32'd0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule